// File: doc/BRIEF.md
# Endpoint FIFO CPU Access Port

This block gives firmware a byte-wide register window onto a bank of per-endpoint FIFOs. Each endpoint owns two FIFOs. The receive FIFO is filled from the endpoint side and drained by the CPU. The transmit FIFO is filled by the CPU and drained from the endpoint side. One one-hot select register names the endpoint whose receive FIFO the CPU reads from, and a second one names the endpoint whose transmit FIFO the CPU writes to. A single data register pops a byte when read and pushes a byte when written. Two enable bits gate these transfers.

Accesses that cannot complete are absorbed without any error. A read that is disabled, that targets an empty FIFO or that has no valid endpoint selected returns 0x00 and pops nothing. A write of the same kinds is dropped. Two 12-bit status counts report the bytes waiting in the selected receive FIFO and the free space in the selected transmit FIFO. Each count is split into a high register and a low register. Reading the high register latches the low byte, so a high-then-low pair always describes one instant.

The endpoint-side push and pop strobes act in the same cycle as CPU accesses, and the counts follow both sides.

Top module: `epf_cpu_port`

## Requirements
- R1: After reset, every register reads 0x00: both selects, control, data and all four count registers.
- R2: A data read (address 3) with read enable set (control bit 0) and a connected read select returns the oldest byte of that endpoint's receive FIFO and removes it. Bytes come out in push order. Read data appears on `cpu_rdata` after the clock edge that samples `cpu_rd` and holds until the next read.
- R3: A data write (address 3) with write enable set (control bit 1) and a connected write select appends the byte to that endpoint's transmit FIFO.
- R4: A data read with read enable clear returns 0x00 and leaves the receive FIFO unchanged.
- R5: A data write with write enable clear is discarded and leaves the transmit FIFO unchanged.
- R6: A data read from an empty receive FIFO returns 0x00 and leaves its count at 0.
- R7: A data write into a transmit FIFO that holds DEPTH (64) bytes is discarded.
- R8: A select value (address 0 for reads, address 1 for writes) is connected only when exactly one of its low NUM_EP bits is set and no other bit is set. With a disconnected select, reads return 0x00, writes are dropped and the matching count reads 0.
- R9: Receive count registers are at address 4 (high) and address 5 (low). Transmit-space registers are at address 6 (high) and address 7 (low). A high register carries count bits 11:8 in bits 3:0, and its bits 7:4 read 0. The receive count is the number of bytes in the selected receive FIFO. The transmit count is DEPTH minus the number of bytes in the selected transmit FIFO.
- R10: Reading a high count register latches the matching low byte. The next read of that low register returns the latched value even if the count has changed since.
- R11: A low count read that has no pending high-register latch returns the live low byte.
- R12: The endpoint side pushes into a receive FIFO and pops from a transmit FIFO. `dev_rd_data` shows the head of the transmit FIFO selected by `dev_rd_ep`. A push into a full FIFO is dropped. An endpoint push and a CPU pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 3 | Register address |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| dev_wr_en | input | 1 | Endpoint-side push into a receive FIFO |
| dev_wr_ep | input | 2 | Endpoint index for the push |
| dev_wr_data | input | 8 | Byte to push |
| dev_rd_en | input | 1 | Endpoint-side pop from a transmit FIFO |
| dev_rd_ep | input | 2 | Endpoint index for the pop and head view |
| dev_rd_data | output | 8 | Head byte of the indexed transmit FIFO |

## Verification
The bench targets the silent-absorption corners. These are disabled, empty, full and disconnected accesses. A design that popped or pushed anyway would show a wrong count or a byte out of order in later reads. A design that returned stale data instead of 0x00 would fail the dummy-value compares. The split-count test changes the count between the high and low reads. A design that ignored the latch would return the new low byte. A design whose latch never cleared would return the old byte on the following low read. A same-cycle endpoint push and CPU pop exposes counters that let one side overwrite the other.

// File: rtl/epf_pkg.sv
package epf_pkg;

    typedef enum logic [2:0] {
        REG_RSEL  = 3'd0,
        REG_WSEL  = 3'd1,
        REG_CTRL  = 3'd2,
        REG_DATA  = 3'd3,
        REG_RC_HI = 3'd4,
        REG_RC_LO = 3'd5,
        REG_WS_HI = 3'd6,
        REG_WS_LO = 3'd7
    } epf_reg_e;

    localparam logic [7:0] DUMMY_BYTE = 8'h00;

endpackage

// File: rtl/epf_fifo.sv
module epf_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[st_q.rptr];
    assign count   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wptr = st_q.wptr + AW'(1);
        if (do_pop)  st_d.rptr = st_q.rptr + AW'(1);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= wdata;
    end

endmodule

// File: rtl/epf_split_count.sv
module epf_split_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] value,
    input  logic             hi_rd,
    input  logic             lo_rd,
    output logic [7:0]       hi_byte,
    output logic [7:0]       lo_byte
);

    typedef struct packed {
        logic [7:0] snap;
        logic       held;
    } snap_t;

    snap_t st_q, st_d;
    logic [15:0] wide;

    assign wide    = 16'(value);
    assign hi_byte = {4'h0, wide[11:8]};
    assign lo_byte = st_q.held ? st_q.snap : wide[7:0];

    always_comb begin
        st_d = st_q;
        if (hi_rd) begin
            st_d.snap = wide[7:0];
            st_d.held = 1'b1;
        end else if (lo_rd) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/epf_cpu_port.sv
module epf_cpu_port
    import epf_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 12,
    localparam int EPW   = $clog2(NUM_EP),
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     cpu_addr,
    input  logic           cpu_rd,
    input  logic           cpu_wr,
    input  logic [7:0]     cpu_wdata,
    output logic [7:0]     cpu_rdata,
    input  logic           dev_wr_en,
    input  logic [EPW-1:0] dev_wr_ep,
    input  logic [7:0]     dev_wr_data,
    input  logic           dev_rd_en,
    input  logic [EPW-1:0] dev_rd_ep,
    output logic [7:0]     dev_rd_data
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [7:0] rsel;
        logic [7:0] wsel;
        logic       rd_en;
        logic       wr_en;
        logic [7:0] rdata;
    } regs_t;

    regs_t regs_q, regs_d;

    logic [7:0]      rx_head  [NUM_EP];
    logic [CW-1:0]   rx_cnt   [NUM_EP];
    logic [NUM_EP-1:0] rx_full, rx_empty, rx_push, rx_pop;
    logic [7:0]      tx_head  [NUM_EP];
    logic [CW-1:0]   tx_cnt   [NUM_EP];
    logic [NUM_EP-1:0] tx_full, tx_empty, tx_push, tx_pop;

    logic [NUM_EP-1:0] rd_hot, wr_hot;
    logic              rd_conn, wr_conn;
    logic [7:0]        rd_head_sel;
    logic              rd_empty_sel, wr_full_sel;
    logic [CNT_W-1:0]  rd_remain, wr_space;
    logic              data_rd_ok, data_wr_ok;
    logic [7:0]        rc_hi, rc_lo, ws_hi, ws_lo;
    logic              rd_en_s;

    // Select decode: connected only for a single bit inside the endpoint range
    assign rd_conn = $onehot(regs_q.rsel) && ((regs_q.rsel >> NUM_EP) == 8'd0);
    assign wr_conn = $onehot(regs_q.wsel) && ((regs_q.wsel >> NUM_EP) == 8'd0);
    assign rd_hot  = rd_conn ? regs_q.rsel[NUM_EP-1:0] : '0;
    assign wr_hot  = wr_conn ? regs_q.wsel[NUM_EP-1:0] : '0;
    assign rd_en_s = regs_q.rd_en;

    always_comb begin
        rd_head_sel  = '0;
        rd_empty_sel = 1'b1;
        wr_full_sel  = 1'b1;
        rd_remain    = '0;
        wr_space     = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (rd_hot[i]) begin
                rd_head_sel  = rx_head[i];
                rd_empty_sel = rx_empty[i];
                rd_remain    = CNT_W'(rx_cnt[i]);
            end
            if (wr_hot[i]) begin
                wr_full_sel = tx_full[i];
                wr_space    = DEPTH_C - CNT_W'(tx_cnt[i]);
            end
        end
    end

    assign data_rd_ok = cpu_rd && (cpu_addr == REG_DATA) && regs_q.rd_en
                        && rd_conn && !rd_empty_sel;
    assign data_wr_ok = cpu_wr && (cpu_addr == REG_DATA) && regs_q.wr_en
                        && wr_conn && !wr_full_sel;

    generate
        for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
            assign rx_push[g] = dev_wr_en && (dev_wr_ep == EPW'(g));
            assign rx_pop[g]  = data_rd_ok && rd_hot[g];
            assign tx_push[g] = data_wr_ok && wr_hot[g];
            assign tx_pop[g]  = dev_rd_en && (dev_rd_ep == EPW'(g));

            epf_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx (
                .clk(clk), .rst_n(rst_n),
                .push(rx_push[g]), .wdata(dev_wr_data),
                .pop(rx_pop[g]), .head(rx_head[g]), .count(rx_cnt[g]),
                .full(rx_full[g]), .empty(rx_empty[g])
            );

            epf_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx (
                .clk(clk), .rst_n(rst_n),
                .push(tx_push[g]), .wdata(cpu_wdata),
                .pop(tx_pop[g]), .head(tx_head[g]), .count(tx_cnt[g]),
                .full(tx_full[g]), .empty(tx_empty[g])
            );
        end
    endgenerate

    assign dev_rd_data = tx_head[dev_rd_ep];

    epf_split_count #(.CNT_W(CNT_W)) u_rc (
        .clk(clk), .rst_n(rst_n), .value(rd_remain),
        .hi_rd(cpu_rd && (cpu_addr == REG_RC_HI)),
        .lo_rd(cpu_rd && (cpu_addr == REG_RC_LO)),
        .hi_byte(rc_hi), .lo_byte(rc_lo)
    );

    epf_split_count #(.CNT_W(CNT_W)) u_ws (
        .clk(clk), .rst_n(rst_n), .value(wr_space),
        .hi_rd(cpu_rd && (cpu_addr == REG_WS_HI)),
        .lo_rd(cpu_rd && (cpu_addr == REG_WS_LO)),
        .hi_byte(ws_hi), .lo_byte(ws_lo)
    );

    always_comb begin
        regs_d = regs_q;
        if (cpu_wr) begin
            case (cpu_addr)
                REG_RSEL: regs_d.rsel = cpu_wdata;
                REG_WSEL: regs_d.wsel = cpu_wdata;
                REG_CTRL: begin
                    regs_d.rd_en = cpu_wdata[0];
                    regs_d.wr_en = cpu_wdata[1];
                end
                default: ;
            endcase
        end
        if (cpu_rd) begin
            case (cpu_addr)
                REG_RSEL:  regs_d.rdata = regs_q.rsel;
                REG_WSEL:  regs_d.rdata = regs_q.wsel;
                REG_CTRL:  regs_d.rdata = {6'd0, regs_q.wr_en, regs_q.rd_en};
                REG_DATA:  regs_d.rdata = data_rd_ok ? rd_head_sel : DUMMY_BYTE;
                REG_RC_HI: regs_d.rdata = rc_hi;
                REG_RC_LO: regs_d.rdata = rc_lo;
                REG_WS_HI: regs_d.rdata = ws_hi;
                default:   regs_d.rdata = ws_lo;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cpu_rdata = regs_q.rdata;

endmodule

// File: rtl/epf_cpu_port_chk.sv
module epf_cpu_port_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cpu_addr,
    input logic             cpu_rd,
    input logic             cpu_wr,
    input logic [7:0]       cpu_rdata,
    input logic             dev_wr_en,
    input logic             dev_rd_en,
    input logic             rd_en,
    input logic             rd_conn,
    input logic [CNT_W-1:0] rd_remain,
    input logic [CNT_W-1:0] wr_space
);

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata));

    p_dummy_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == 3'd3 && !rd_en) |=> (cpu_rdata == 8'h00));

    p_no_pop_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == 3'd3 && !rd_en && !cpu_wr && !dev_wr_en)
        |=> $stable(rd_remain));

    p_empty_dummy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == 3'd3 && rd_remain == '0) |=> (cpu_rdata == 8'h00));

    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 3'd3 && wr_space == '0 && !dev_rd_en)
        |=> (wr_space == '0));

    p_unconnected_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_conn |-> (rd_remain == '0));

    p_hi_nibble_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (cpu_addr == 3'd4 || cpu_addr == 3'd6)) |=> (cpu_rdata[7:4] == 4'h0));

endmodule

bind epf_cpu_port epf_cpu_port_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .dev_wr_en(dev_wr_en),
    .dev_rd_en(dev_rd_en), .rd_en(rd_en_s), .rd_conn(rd_conn),
    .rd_remain(rd_remain), .wr_space(wr_space)
);

// File: tb/epf_cpu_port_tb.sv
module epf_cpu_port_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       dev_wr_en = 1'b0;
    logic [1:0] dev_wr_ep = '0;
    logic [7:0] dev_wr_data = '0;
    logic       dev_rd_en = 1'b0;
    logic [1:0] dev_rd_ep = '0;
    logic [7:0] dev_rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       pend = 1'b0;
    logic       done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epf_cpu_port u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dev_wr_en(dev_wr_en), .dev_wr_ep(dev_wr_ep), .dev_wr_data(dev_wr_data),
        .dev_rd_en(dev_rd_en), .dev_rd_ep(dev_rd_ep), .dev_rd_data(dev_rd_data)
    );

    // Monitor: compares each captured read against the scoreboard queue
    always @(posedge clk) pend <= cpu_rd;

    always @(negedge clk) begin
        if (pend) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (cpu_rdata !== e) begin
                errors++;
                $display("FAIL %s: cpu_rdata actual %02h expected %02h", t, cpu_rdata, e);
            end
        end
    end

    task automatic cpu_read(input logic [2:0] a, input logic [7:0] e, input string t);
        cpu_addr = a;
        cpu_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic dev_push(input logic [1:0] ep, input logic [7:0] d);
        dev_wr_ep   = ep;
        dev_wr_data = d;
        dev_wr_en   = 1'b1;
        @(negedge clk);
        dev_wr_en = 1'b0;
    endtask

    task automatic dev_pop(input logic [1:0] ep, input logic [7:0] e, input string t);
        dev_rd_ep = ep;
        #1;
        checks++;
        if (dev_rd_data !== e) begin
            errors++;
            $display("FAIL %s: dev_rd_data actual %02h expected %02h", t, dev_rd_data, e);
        end
        dev_rd_en = 1'b1;
        @(negedge clk);
        dev_rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of all registers
        for (int a = 0; a < 8; a++) cpu_read(3'(a), 8'h00, "R1 reset");

        cpu_write(3'd2, 8'h03);
        cpu_write(3'd0, 8'h01);
        cpu_write(3'd1, 8'h04);
        cpu_read(3'd2, 8'h03, "R1 ctrl readback");

        // R2 / R9 / R11: fill ep0 receive FIFO, read counts and data
        dev_push(2'd0, 8'hA1);
        dev_push(2'd0, 8'hA2);
        dev_push(2'd0, 8'hA3);
        cpu_read(3'd5, 8'd3, "R11 live low count");
        cpu_read(3'd4, 8'h00, "R9 rx high");
        cpu_read(3'd5, 8'd3, "R9 rx low");
        cpu_read(3'd3, 8'hA1, "R2 first byte");
        cpu_read(3'd3, 8'hA2, "R2 second byte");
        cpu_read(3'd5, 8'd1, "R2 count after pops");

        // R4: read disabled
        cpu_write(3'd2, 8'h02);
        cpu_read(3'd3, 8'h00, "R4 disabled read dummy");
        cpu_read(3'd5, 8'd1, "R4 no pop");
        cpu_write(3'd2, 8'h03);
        cpu_read(3'd3, 8'hA3, "R4 byte kept");

        // R6: empty read
        cpu_read(3'd3, 8'h00, "R6 empty dummy");
        cpu_read(3'd5, 8'd0, "R6 count stays 0");

        // R3 / R12: CPU writes to ep2 transmit FIFO
        cpu_write(3'd3, 8'h11);
        cpu_write(3'd3, 8'h22);
        cpu_read(3'd7, 8'd62, "R9 tx space");
        dev_pop(2'd2, 8'h11, "R3 first tx byte");
        dev_pop(2'd2, 8'h22, "R12 second tx byte");

        // R5: write disabled
        cpu_write(3'd2, 8'h01);
        cpu_write(3'd3, 8'h33);
        cpu_read(3'd7, 8'd64, "R5 write dropped");
        cpu_write(3'd2, 8'h03);

        // R7: fill to DEPTH, overflow write dropped
        for (int i = 0; i < 64; i++) cpu_write(3'd3, 8'(i + 8'h80));
        cpu_read(3'd6, 8'h00, "R7 tx high at full");
        cpu_read(3'd7, 8'h00, "R7 tx low at full");
        cpu_write(3'd3, 8'hEE);
        cpu_read(3'd7, 8'h00, "R7 still full");
        for (int i = 0; i < 64; i++) dev_pop(2'd2, 8'(i + 8'h80), "R7 drain order");
        cpu_read(3'd7, 8'd64, "R7 empty again");

        // R10 / R11: snapshot coherence on ep1
        cpu_write(3'd0, 8'h02);
        for (int i = 0; i < 5; i++) dev_push(2'd1, 8'(8'h50 + i));
        cpu_read(3'd4, 8'h00, "R10 high read");
        dev_push(2'd1, 8'h55);
        cpu_read(3'd5, 8'd5, "R10 latched low");
        cpu_read(3'd5, 8'd6, "R11 live after latch");

        // R8: disconnected selects
        cpu_write(3'd0, 8'h03);
        cpu_read(3'd5, 8'd0, "R8 multi-bit count");
        cpu_read(3'd3, 8'h00, "R8 multi-bit dummy");
        cpu_write(3'd0, 8'h10);
        cpu_read(3'd3, 8'h00, "R8 out-of-range dummy");
        cpu_write(3'd0, 8'h02);
        cpu_read(3'd5, 8'd6, "R8 no pop occurred");
        cpu_write(3'd1, 8'h00);
        cpu_write(3'd3, 8'h77);
        cpu_read(3'd7, 8'd0, "R8 zero select space");
        cpu_write(3'd1, 8'h04);
        cpu_read(3'd7, 8'd64, "R8 write dropped");

        // R12: endpoint overflow and same-cycle push/pop
        for (int i = 0; i < 60; i++) dev_push(2'd1, 8'(8'h60 + i));
        cpu_read(3'd5, 8'h40, "R12 rx full count");
        cpu_read(3'd3, 8'h50, "R12 oldest byte");
        cpu_addr    = 3'd3;
        cpu_rd      = 1'b1;
        exp_q.push_back(8'h51);
        tag_q.push_back("R12 simultaneous pop");
        dev_wr_ep   = 2'd1;
        dev_wr_data = 8'h99;
        dev_wr_en   = 1'b1;
        @(negedge clk);
        cpu_rd    = 1'b0;
        dev_wr_en = 1'b0;
        cpu_read(3'd5, 8'd63, "R12 count steady");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule